// File: doc/BRIEF.md
# Streaming Radix-2^2 Inverse FFT

The block is a pipelined inverse FFT of fixed power-of-four length N. It takes one complex fixed-point sample per clock, qualified by a valid flag. It returns one complex sample per clock in bit-reversed order, with a valid flag and one-cycle frame start and frame end markers. Its butterfly stages work in pairs. Each stage has a single-path delay-feedback memory. The first stage of each pair applies a quarter-turn rotation by swapping the real and imaginary parts and changing one sign, so that stage needs no multiplier. A complex twiddle multiplier sits between pairs. Its table holds the conjugate roots exp(+j2πk/N), so the result is the inverse transform.

Input may arrive with gaps. Each stage counts only its own valid samples. Each stage also empties its stored differences by itself, so a frame drains through the pipeline without any further input. When frames arrive back to back, the output is continuous. Normalisation is a parameter. When it is on, every butterfly halves its result, giving an overall 1/N scale at the input width. When it is off, the internal and output width is DW+log2(N) and nothing is halved.

Top module: `ifft_r22sdf`

## Requirements
- R1: After reset, valid_o, start_o and end_o are 0, and they stay 0 while no valid input arrives.
- R2: With normalisation on, output position p of a frame equals (1/N)·Σn x[n]·exp(+j2π·n·k/N) for k = bitrev(p), within 4 LSB, where x[n] is the n-th valid input of the frame.
- R3: The output is in bit-reversed order. A tone x[n] = A·exp(-j2πn/N) puts its energy only at output position bitrev(1), which is N/2.
- R4: Only cycles with valid_i = 1 carry samples. The same frame sent with idle gaps gives the same output values as the same frame sent contiguously.
- R5: When two frames are sent back to back, valid_o is high for 2N consecutive cycles.
- R6: start_o is 1 exactly with the first valid output of each frame. end_o is 1 exactly with the N-th, which is the last.
- R7: Reset in the middle of a frame discards the partial frame. The next frame produces exactly N outputs, each matching that frame alone.
- R8: With normalisation off, outputs are N times the R2 values, within 4 LSB, at width DW+log2(N). A constant input A gives exactly N·A at position 0.
- R9: A butterfly stage emits its stored differences in the cycles directly after the last sample of a group. This never coincides with a sample arriving in the second half of a group.
- R10: Twiddles are DW bits wide with DW-2 fractional bits, so 1.0 is exact. Products are rounded down (floor) to the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all state |
| valid_i | input | 1 | Input sample qualifier |
| re_i | input | DW | Real part of input sample, signed |
| im_i | input | DW | Imaginary part of input sample, signed |
| valid_o | output | 1 | Output sample qualifier |
| re_o | output | IW | Real part of output, signed; IW = DW, or DW+log2(N) when normalisation is off |
| im_o | output | IW | Imaginary part of output, signed |
| start_o | output | 1 | First output of a frame |
| end_o | output | 1 | Last output of a frame |

## Verification
Back-to-back frames create two overlaps. Within a stage, the stored differences of one frame drain in the same cycles that the first half of the next frame is written into the delay memory. At the output, the end pulse of one frame is followed in the very next cycle by the start pulse of the next. The bench sends two different frames with no gap between them. It then checks that the 2N outputs arrive in consecutive cycles, that the markers fall at positions 0, N-1, N and 2N-1, and that each frame matches its own reference inverse DFT. A drain colliding with a stored sample would corrupt the first frame's values.

// File: rtl/ifft_r22_pkg.sv
package ifft_r22_pkg;
  localparam real TWO_PI = 6.283185307179586;

  function automatic int round_real(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  // maps output block order of a stage pair to its twiddle multiple
  function automatic logic [1:0] rev2(input logic [1:0] q);
    return {q[0], q[1]};
  endfunction
endpackage

// File: rtl/ifft_sdf_stage.sv
module ifft_sdf_stage #(
  parameter int IW   = 16,
  parameter int SPAN = 8,
  parameter bit ROT  = 1'b0,
  parameter bit NORM = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic signed [IW-1:0] re_i,
  input  logic signed [IW-1:0] im_i,
  output logic                 v_o,
  output logic signed [IW-1:0] re_o,
  output logic signed [IW-1:0] im_o
);
  localparam int CW = $clog2(2 * SPAN);
  localparam int AW = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int SH = NORM ? 1 : 0;

  logic [CW-1:0] cnt;
  logic [AW-1:0] wa, dptr;
  logic drain, half, last, rot;
  logic signed [IW-1:0] mem_re [SPAN];
  logic signed [IW-1:0] mem_im [SPAN];
  logic signed [IW:0]   sum_re, sum_im, dif_re, dif_im;
  logic signed [IW-1:0] sr, si, dr, di, wr, wi;

  if (SPAN > 1) begin : g_addr
    assign wa = cnt[AW-1:0];
  end else begin : g_addr_one
    assign wa = '0;
  end

  assign half = cnt[CW-1];
  assign last = (cnt == CW'(2 * SPAN - 1));
  assign rot  = ROT && (wa >= AW'(SPAN / 2));

  always_comb begin
    sum_re = mem_re[wa] + re_i;
    sum_im = mem_im[wa] + im_i;
    dif_re = mem_re[wa] - re_i;
    dif_im = mem_im[wa] - im_i;
    sr = IW'(sum_re >>> SH);
    si = IW'(sum_im >>> SH);
    dr = IW'(dif_re >>> SH);
    di = IW'(dif_im >>> SH);
    // quarter turn (+j): swap parts, negate the new real part
    wr = rot ? -di : dr;
    wi = rot ? dr  : di;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      dptr  <= '0;
      drain <= 1'b0;
      v_o   <= 1'b0;
      re_o  <= '0;
      im_o  <= '0;
      for (int i = 0; i < SPAN; i++) begin
        mem_re[i] <= '0;
        mem_im[i] <= '0;
      end
    end else begin
      v_o <= 1'b0;
      if (drain) begin
        v_o  <= 1'b1;
        re_o <= mem_re[dptr];
        im_o <= mem_im[dptr];
        if (dptr == AW'(SPAN - 1)) drain <= 1'b0;
        else dptr <= dptr + 1'b1;
      end
      if (v_i) begin
        cnt <= cnt + 1'b1;
        if (!half) begin
          mem_re[wa] <= re_i;
          mem_im[wa] <= im_i;
        end else begin
          mem_re[wa] <= wr;
          mem_im[wa] <= wi;
          v_o  <= 1'b1;
          re_o <= sr;
          im_o <= si;
          if (last) begin
            drain <= 1'b1;
            dptr  <= '0;
          end
        end
      end
    end
  end

  // R9: draining never overlaps a second-half sample
  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && half) |-> !drain);
  // R9: draining starts right after the group's last sample
  a_r9_drain_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i && last) |=> (drain && v_o));
endmodule

// File: rtl/ifft_twiddle.sv
module ifft_twiddle import ifft_r22_pkg::*; #(
  parameter int IW    = 16,
  parameter int TW    = 16,
  parameter int N     = 16,
  parameter int QSPAN = 4,
  parameter int STEP  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic signed [IW-1:0] re_i,
  input  logic signed [IW-1:0] im_i,
  output logic                 v_o,
  output logic signed [IW-1:0] re_o,
  output logic signed [IW-1:0] im_o
);
  localparam int  LG = $clog2(N);
  localparam int  CW = $clog2(4 * QSPAN);
  localparam int  PW = IW + TW + 1;
  localparam real SC = real'(1 << (TW - 2));

  logic [CW-1:0] cnt;
  logic [LG-1:0] idx;
  logic signed [TW-1:0] rom_c [N];
  logic signed [TW-1:0] rom_s [N];
  logic signed [TW-1:0] c, s;
  logic signed [PW-1:0] pr, pi;

  for (genvar i = 0; i < N; i++) begin : g_rom
    localparam int CV = round_real(SC * $cos(TWO_PI * real'(i) / real'(N)));
    localparam int SV = round_real(SC * $sin(TWO_PI * real'(i) / real'(N)));
    assign rom_c[i] = TW'(CV);
    assign rom_s[i] = TW'(SV);
  end

  // block q of four, position k within block: exponent k*STEP*rev2(q)
  assign idx = LG'(int'(cnt[CW-3:0]) * STEP * int'(rev2(cnt[CW-1:CW-2])));
  assign c   = rom_c[idx];
  assign s   = rom_s[idx];
  assign pr  = re_i * c - im_i * s;
  assign pi  = re_i * s + im_i * c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= '0;
      v_o  <= 1'b0;
      re_o <= '0;
      im_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        cnt  <= cnt + 1'b1;
        re_o <= IW'(pr >>> (TW - 2));
        im_o <= IW'(pi >>> (TW - 2));
      end
    end
  end
endmodule

// File: rtl/ifft_r22sdf.sv
module ifft_r22sdf #(
  parameter int N    = 16,
  parameter int DW   = 16,
  parameter bit NORM = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic signed [DW-1:0]   re_i,
  input  logic signed [DW-1:0]   im_i,
  output logic                   valid_o,
  output logic signed [(NORM ? DW : DW + $clog2(N))-1:0] re_o,
  output logic signed [(NORM ? DW : DW + $clog2(N))-1:0] im_o,
  output logic                   start_o,
  output logic                   end_o
);
  localparam int LOG2N = $clog2(N);
  localparam int NPAIR = LOG2N / 2;
  localparam int IW    = NORM ? DW : DW + LOG2N;

  logic                 p_v  [NPAIR+1];
  logic signed [IW-1:0] p_re [NPAIR+1];
  logic signed [IW-1:0] p_im [NPAIR+1];
  logic                 m_v  [NPAIR];
  logic signed [IW-1:0] m_re [NPAIR];
  logic signed [IW-1:0] m_im [NPAIR];
  logic                 b_v  [NPAIR];
  logic signed [IW-1:0] b_re [NPAIR];
  logic signed [IW-1:0] b_im [NPAIR];
  logic [LOG2N-1:0]     oc;

  assign p_v[0]  = valid_i;
  assign p_re[0] = IW'(re_i);
  assign p_im[0] = IW'(im_i);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    ifft_sdf_stage #(.IW(IW), .SPAN(N >> (2*p + 1)), .ROT(1'b1), .NORM(NORM)) i_bf_a (
      .clk_i, .rst_ni, .v_i(p_v[p]), .re_i(p_re[p]), .im_i(p_im[p]),
      .v_o(m_v[p]), .re_o(m_re[p]), .im_o(m_im[p]));
    ifft_sdf_stage #(.IW(IW), .SPAN(N >> (2*p + 2)), .ROT(1'b0), .NORM(NORM)) i_bf_b (
      .clk_i, .rst_ni, .v_i(m_v[p]), .re_i(m_re[p]), .im_i(m_im[p]),
      .v_o(b_v[p]), .re_o(b_re[p]), .im_o(b_im[p]));
    if (p < NPAIR - 1) begin : g_tw
      ifft_twiddle #(.IW(IW), .TW(DW), .N(N), .QSPAN(N >> (2*p + 2)), .STEP(1 << (2*p))) i_tw (
        .clk_i, .rst_ni, .v_i(b_v[p]), .re_i(b_re[p]), .im_i(b_im[p]),
        .v_o(p_v[p+1]), .re_o(p_re[p+1]), .im_o(p_im[p+1]));
    end else begin : g_last
      assign p_v[p+1]  = b_v[p];
      assign p_re[p+1] = b_re[p];
      assign p_im[p+1] = b_im[p];
    end
  end

  assign valid_o = p_v[NPAIR];
  assign re_o    = p_re[NPAIR];
  assign im_o    = p_im[NPAIR];
  assign start_o = valid_o && (oc == '0);
  assign end_o   = valid_o && (oc == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc <= '0;
    else if (valid_o) oc <= oc + 1'b1;
  end

  // R6: a frame marker pair never shares one cycle
  a_r6_single_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && end_o));
  // R6: the output after a frame end opens a new frame
  a_r6_end_then_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(end_o)) |-> start_o);
endmodule

// File: tb/test_ifft_r22sdf.sv
module test_ifft_r22sdf;
  localparam int N = 16, DW = 16, LG = 4, RW = DW + LG;
  localparam real TOL = 4.0;
  localparam real TP = 6.283185307179586;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, vin;
  logic signed [DW-1:0] xr, xi;
  logic vo, so, eo, rvo, rso, reo;
  logic signed [DW-1:0] ro, io;
  logic signed [RW-1:0] rro, rio;

  ifft_r22sdf #(.N(N), .DW(DW), .NORM(1'b1)) i_ifft_r22sdf (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .re_i(xr), .im_i(xi),
    .valid_o(vo), .re_o(ro), .im_o(io), .start_o(so), .end_o(eo));
  ifft_r22sdf #(.N(N), .DW(DW), .NORM(1'b0)) i_ifft_r22sdf_raw (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .re_i(xr), .im_i(xi),
    .valid_o(rvo), .re_o(rro), .im_o(rio), .start_o(rso), .end_o(reo));

  int total = 0, bad = 0, cyc = 0;
  int cap_n = 0, raw_n = 0;
  int cap_re [64], cap_im [64], cap_cyc [64], raw_re [64], raw_im [64];
  bit cap_st [64], cap_en [64];
  int fr_re [2][N], fr_im [2][N];

  always @(negedge clk) begin
    cyc++;
    if (vo) begin
      if (cap_n < 64) begin
        cap_re[cap_n] = int'(ro); cap_im[cap_n] = int'(io);
        cap_st[cap_n] = so; cap_en[cap_n] = eo; cap_cyc[cap_n] = cyc;
      end
      cap_n++;
    end
    if (rvo) begin
      if (raw_n < 64) begin raw_re[raw_n] = int'(rro); raw_im[raw_n] = int'(rio); end
      raw_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int brev(input int p);
    int r = 0;
    for (int b = 0; b < LG; b++) if (p & (1 << b)) r |= 1 << (LG - 1 - b);
    return r;
  endfunction

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic drive_frame(input int f, input bit gaps);
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      vin = 1'b1; xr = DW'(fr_re[f][n]); xi = DW'(fr_im[f][n]);
      if (gaps && (n % 3 == 1)) begin
        @(negedge clk); vin = 1'b0;
        @(negedge clk); vin = 1'b0;
      end
    end
  endtask

  task automatic go_idle();
    @(negedge clk); vin = 1'b0;
  endtask

  task automatic clear_cap();
    cap_n = 0; raw_n = 0;
  endtask

  task automatic wait_out(input int want, input string req);
    for (int i = 0; i < 400 && cap_n < want; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(cap_n == want, req, "output count", cap_n, want);
  endtask

  // compare captured outputs [base, base+N) with inverse DFT of frame f
  task automatic check_frame(input int f, input int base, input bit raw, input string req);
    for (int p = 0; p < N; p++) begin
      int k = brev(p);
      real ar = 0.0, ai = 0.0;
      for (int n = 0; n < N; n++) begin
        real a = TP * real'((n * k) % N) / real'(N);
        ar += real'(fr_re[f][n]) * $cos(a) - real'(fr_im[f][n]) * $sin(a);
        ai += real'(fr_re[f][n]) * $sin(a) + real'(fr_im[f][n]) * $cos(a);
      end
      if (!raw) begin ar = ar / real'(N); ai = ai / real'(N); end
      begin
        int gr = raw ? raw_re[base + p] : cap_re[base + p];
        int gi = raw ? raw_im[base + p] : cap_im[base + p];
        chk(absr(real'(gr) - ar) <= TOL, req, $sformatf("re pos %0d", p), gr, rnd(ar));
        chk(absr(real'(gi) - ai) <= TOL, req, $sformatf("im pos %0d", p), gi, rnd(ai));
      end
    end
  endtask

  task automatic load_rand(input int f, input int seed);
    int s = seed;
    for (int n = 0; n < N; n++) begin
      s = s * 1103515245 + 12345;
      fr_re[f][n] = ((s >>> 8) % 4000);
      s = s * 1103515245 + 12345;
      fr_im[f][n] = ((s >>> 8) % 4000);
    end
  endtask

  task automatic t_reset_idle();
    chk(vo == 1'b0 && so == 1'b0 && eo == 1'b0, "R1", "outputs in reset", int'(vo), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(cap_n == 0, "R1", "outputs while idle", cap_n, 0);
  endtask

  task automatic t_tone();
    for (int n = 0; n < N; n++) begin
      fr_re[0][n] = rnd(8000.0 * $cos(TP * real'(n) / real'(N)));
      fr_im[0][n] = rnd(-8000.0 * $sin(TP * real'(n) / real'(N)));
    end
    clear_cap(); drive_frame(0, 1'b0); go_idle(); wait_out(N, "R3");
    chk(cap_re[N/2] > 8000 - 5 && cap_re[N/2] < 8000 + 5, "R3", "tone at bitrev(1)", cap_re[N/2], 8000);
    for (int p = 0; p < N; p++)
      if (p != N/2)
        chk(cap_re[p] <= 4 && cap_re[p] >= -4 && cap_im[p] <= 4 && cap_im[p] >= -4,
            "R3", $sformatf("no energy pos %0d", p), cap_re[p], 0);
    check_frame(0, 0, 1'b0, "R2");
  endtask

  task automatic t_random(input bit gaps, input string req);
    load_rand(0, 77);
    clear_cap(); drive_frame(0, gaps); go_idle(); wait_out(N, req);
    check_frame(0, 0, 1'b0, req);
  endtask

  task automatic t_back_to_back();
    bit st_ok = 1'b1, en_ok = 1'b1, ct_ok = 1'b1;
    load_rand(0, 5); load_rand(1, 901);
    clear_cap(); drive_frame(0, 1'b0); drive_frame(1, 1'b0); go_idle(); wait_out(2 * N, "R5");
    for (int i = 0; i < 2 * N - 1; i++) if (cap_cyc[i + 1] != cap_cyc[i] + 1) ct_ok = 1'b0;
    chk(ct_ok, "R5", "contiguous output", cap_cyc[2*N-1] - cap_cyc[0], 2 * N - 1);
    for (int i = 0; i < 2 * N; i++) begin
      if (cap_st[i] != (i % N == 0)) st_ok = 1'b0;
      if (cap_en[i] != (i % N == N - 1)) en_ok = 1'b0;
    end
    chk(st_ok, "R6", "start marker positions", int'(st_ok), 1);
    chk(en_ok, "R6", "end marker positions", int'(en_ok), 1);
    check_frame(0, 0, 1'b0, "R9");
    check_frame(1, N, 1'b0, "R9");
  endtask

  task automatic t_reset_mid();
    load_rand(0, 3131);
    for (int n = 0; n < 12; n++) begin
      @(negedge clk); vin = 1'b1; xr = DW'(fr_re[0][n]); xi = DW'(fr_im[0][n]);
    end
    @(negedge clk); vin = 1'b0; rst_n = 1'b0;
    #1 chk(vo == 1'b0, "R7", "valid in reset", int'(vo), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    load_rand(0, 4242);
    clear_cap(); drive_frame(0, 1'b0); go_idle(); wait_out(N, "R7");
    chk(cap_st[0] == 1'b1, "R7", "first output starts frame", int'(cap_st[0]), 1);
    check_frame(0, 0, 1'b0, "R7");
  endtask

  task automatic t_raw();
    for (int n = 0; n < N; n++) begin fr_re[0][n] = 1000; fr_im[0][n] = 0; end
    clear_cap(); drive_frame(0, 1'b0); go_idle(); wait_out(N, "R8");
    chk(raw_n == N, "R8", "raw output count", raw_n, N);
    chk(raw_re[0] == 16000 && raw_im[0] == 0, "R8", "raw dc bin", raw_re[0], 16000);
    chk(cap_re[0] == 1000 && cap_im[0] == 0, "R10", "scaled dc bin exact", cap_re[0], 1000);
    load_rand(0, 99);
    clear_cap(); drive_frame(0, 1'b0); go_idle(); wait_out(N, "R8");
    check_frame(0, 0, 1'b1, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vin = 1'b0; xr = '0; xi = '0;
    repeat (3) @(negedge clk);
    t_reset_idle();
    t_tone();
    t_random(1'b0, "R2");
    t_random(1'b1, "R4");
    t_back_to_back();
    t_reset_mid();
    t_raw();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule